// File: doc/BRIEF.md
# Dynamic Link Width Change Controller

This controller handles runtime lane-count changes for one port of a multi-lane serial link while the link is in its normal active state. A local requester asks for a new width. The controller then exchanges abstract request and acknowledge strobes with the link partner. It follows per-lane indications from the receive path: electrical-idle ordered sets on lanes being shut down, and training-set completion, deskew, and start-of-data on lanes being brought up. It keeps separate transmit and receive lane masks.

The controller settles crossing requests from both ends with a fixed tie-break. It accepts idle ordered sets on the departing lanes as an acknowledge that never arrived. After an acknowledged change that never completes, it refuses new requests for a fixed interval. It raises a retrain request on partial idle detection, on a failed upsize, or when recovery starts in the middle of a change. A low-power-idle entry always takes precedence over a width change.

Top module: `link_width_ctrl`

## Requirements
- R1: After reset both lane masks are all ones (full width LANES), and retrain_o, tx_req_o, tx_ack_o, req_reject_o and l1_ack_o are low.
- R2: In the idle state, a local request whose width is 1..LANES and differs from the current width produces tx_req_o with tx_req_width_o equal to that width one cycle later. A width of 0, a width above LANES, or a width equal to the current width instead gives req_reject_o one cycle later and no tx_req_o.
- R3: A valid partner request received in the idle state is answered with tx_ack_o one cycle later. For a downsize, the transmit mask narrows to the new width in that same cycle.
- R4: When a valid local request and a valid partner request arrive in the same cycle, the outcome depends on LOCAL_WINS. With LOCAL_WINS=1, only tx_req_o is sent and the partner request is ignored. With LOCAL_WINS=0, the local request is dropped with req_reject_o, tx_ack_o is sent and the partner's width is adopted.
- R5: During a downsize, the transmit mask narrows when the acknowledge arrives. The receive mask stays wide until every removed lane (lanes at or above the new width) has reported an idle ordered set, and it narrows one cycle after the last of them.
- R6: While a local downsize request awaits its acknowledge, an idle ordered set on any removed lane counts as the acknowledge.
- R7: If some but not all removed lanes report the idle ordered set within SKEW_CYC cycles of the first one, retrain_o rises and the receive mask is left unchanged.
- R8: During an upsize, once every added lane has reported training-set completion and deskew, a start-of-data on an added lane widens both masks one cycle later.
- R9: During an upsize, a training-set failure on an added lane, or a start-of-data on an added lane before all added lanes are trained and deskewed, raises retrain_o one cycle later.
- R10: An acknowledged change that has not completed TMO_CYC cycles after the acknowledge is abandoned. The masks return to the old width, and local requests get req_reject_o for the next TMO_CYC cycles. After that they are accepted again.
- R11: l1_enter_i gives l1_ack_o one cycle later (except while retraining) and outranks width changes. A local request in the same cycle is rejected, a partner request in the same cycle gets no acknowledge, and a change in progress is cut short with both masks restored to the current receive width.
- R12: recovery_enter_i during a change sets the transmit mask to full width and raises retrain_o, while the receive mask keeps its width. retrain_done_i then restores both masks to full and drops retrain_o. recovery_enter_i in the idle state has no effect.
- R13: A lane mask for width w has bit i set exactly when i < w, so the active lanes are always contiguous from lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loc_req_i | input | 1 | Local width-change request strobe |
| loc_width_i | input | $clog2(LANES+1) | Requested width for the local request |
| rx_req_i | input | 1 | Width request received from the partner |
| rx_req_width_i | input | $clog2(LANES+1) | Width named in the partner request |
| rx_ack_i | input | 1 | Acknowledge received from the partner |
| lane_eios_i | input | LANES | Per-lane electrical-idle ordered set seen |
| lane_ts_done_i | input | LANES | Per-lane training-set handshake complete |
| lane_ts_fail_i | input | LANES | Per-lane training-set handshake failed |
| lane_deskew_i | input | LANES | Per-lane deskew achieved |
| lane_sds_i | input | LANES | Per-lane start-of-data seen |
| l1_enter_i | input | 1 | Low-power idle entry negotiated |
| recovery_enter_i | input | 1 | Link enters recovery |
| retrain_done_i | input | 1 | Retraining finished at full width |
| tx_req_o | output | 1 | Send width request to partner |
| tx_req_width_o | output | $clog2(LANES+1) | Width carried by the sent request |
| tx_ack_o | output | 1 | Send acknowledge to partner |
| req_reject_o | output | 1 | Local request refused |
| l1_ack_o | output | 1 | Low-power idle entry accepted |
| retrain_o | output | 1 | Link retraining required |
| tx_mask_o | output | LANES | Active transmit lanes |
| rx_mask_o | output | LANES | Active receive lanes |

## Verification
Two pairs of events can fall in the same cycle: a local request together with a partner request, and a local request together with a low-power-idle entry. The bench provokes the first by driving a downsize to 4 and a partner downsize to 6 in one cycle into two instances that differ only in LOCAL_WINS. It expects one instance to send only its request and the other to reject its own request, acknowledge the partner and narrow its transmit mask to 6 lanes. For the second pair, it expects l1_ack_o and req_reject_o together with no outgoing request. It then cuts short a downsize already in flight and expects the full masks back.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_SENT,
    ST_WAIT_EIOS,
    ST_UPSIZE,
    ST_BLOCKED,
    ST_RETRAIN
  } lwc_state_e;
endpackage

// File: rtl/lwc_width_mask.sv
module lwc_width_mask #(
  parameter int LANES = 8,
  localparam int WW = $clog2(LANES + 1)
) (
  input  logic [WW-1:0]    width_i,
  output logic [LANES-1:0] mask_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask_o[g] = (32'(width_i) > 32'(g));
  end
endmodule

// File: rtl/lwc_lane_acc.sv
module lwc_lane_acc #(
  parameter int LANES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LANES-1:0] set_i,
  output logic [LANES-1:0] acc_o,
  output logic [LANES-1:0] seen_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hit_q <= 1'b0;
      else if (!en_i)  hit_q <= 1'b0;
      else if (set_i[g]) hit_q <= 1'b1;
    end
    assign acc_o[g]  = hit_q;
    assign seen_o[g] = hit_q | (en_i & set_i[g]);
  end
endmodule

// File: rtl/lwc_timer.sv
module lwc_timer #(
  parameter int CNT_MAX = 32,
  localparam int CW = $clog2(CNT_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= CW'(CNT_MAX);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/link_width_ctrl.sv
module link_width_ctrl
  import lwc_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int TMO_CYC    = 32,
  parameter int SKEW_CYC   = 4,
  parameter bit LOCAL_WINS = 1'b1,
  localparam int WW = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             loc_req_i,
  input  logic [WW-1:0]    loc_width_i,
  input  logic             rx_req_i,
  input  logic [WW-1:0]    rx_req_width_i,
  input  logic             rx_ack_i,
  input  logic [LANES-1:0] lane_eios_i,
  input  logic [LANES-1:0] lane_ts_done_i,
  input  logic [LANES-1:0] lane_ts_fail_i,
  input  logic [LANES-1:0] lane_deskew_i,
  input  logic [LANES-1:0] lane_sds_i,
  input  logic             l1_enter_i,
  input  logic             recovery_enter_i,
  input  logic             retrain_done_i,
  output logic             tx_req_o,
  output logic [WW-1:0]    tx_req_width_o,
  output logic             tx_ack_o,
  output logic             req_reject_o,
  output logic             l1_ack_o,
  output logic             retrain_o,
  output logic [LANES-1:0] tx_mask_o,
  output logic [LANES-1:0] rx_mask_o
);
  localparam logic [WW-1:0] FULL_W = WW'(LANES);

  lwc_state_e    st_q, st_d;
  logic [WW-1:0] tx_w_q, tx_w_d, rx_w_q, rx_w_d, tgt_q, tgt_d, req_w_q, req_w_d;
  logic          down_q, down_d;
  logic          tx_req_q, tx_req_d, tx_ack_q, tx_ack_d, rej_q, rej_d, l1a_q, l1a_d;

  logic [LANES-1:0] rx_m, tgt_m, removed, added;
  logic [LANES-1:0] eios_acc, eios_seen, ts_acc, ts_seen, dsk_acc, dsk_seen;
  logic eios_en, up_en, eios_any, eios_all, eios_started, up_ready;
  logic skew_done, chg_done, loc_ok, rmt_ok;

  lwc_width_mask #(.LANES(LANES)) i_tx_mask  (.width_i(tx_w_q), .mask_o(tx_mask_o));
  lwc_width_mask #(.LANES(LANES)) i_rx_mask  (.width_i(rx_w_q), .mask_o(rx_m));
  lwc_width_mask #(.LANES(LANES)) i_tgt_mask (.width_i(tgt_q),  .mask_o(tgt_m));

  assign removed = rx_m & ~tgt_m;
  assign added   = tgt_m & ~rx_m;

  assign eios_en = ((st_q == ST_REQ_SENT) && down_q) || (st_q == ST_WAIT_EIOS);
  assign up_en   = (st_q == ST_UPSIZE);

  lwc_lane_acc #(.LANES(LANES)) i_eios_acc (
    .clk_i, .rst_ni, .en_i(eios_en), .set_i(lane_eios_i), .acc_o(eios_acc), .seen_o(eios_seen));
  lwc_lane_acc #(.LANES(LANES)) i_ts_acc (
    .clk_i, .rst_ni, .en_i(up_en), .set_i(lane_ts_done_i), .acc_o(ts_acc), .seen_o(ts_seen));
  lwc_lane_acc #(.LANES(LANES)) i_dsk_acc (
    .clk_i, .rst_ni, .en_i(up_en), .set_i(lane_deskew_i), .acc_o(dsk_acc), .seen_o(dsk_seen));

  assign eios_any     = |(eios_seen & removed);
  assign eios_all     = ((eios_seen & removed) == removed);
  assign eios_started = |(eios_acc & removed);
  assign up_ready     = ((ts_seen & added) == added) && ((dsk_seen & added) == added);

  // skew window held loaded until the first removed lane reports idle
  lwc_timer #(.CNT_MAX(SKEW_CYC)) i_skew_tmr (
    .clk_i, .rst_ni, .load_i(!eios_started), .done_o(skew_done));
  // reloaded on every state change: ack wait, change window, block window
  lwc_timer #(.CNT_MAX(TMO_CYC)) i_chg_tmr (
    .clk_i, .rst_ni, .load_i(st_d != st_q), .done_o(chg_done));

  function automatic logic width_ok(input logic [WW-1:0] w, input logic [WW-1:0] cur);
    return (w != '0) && (w <= FULL_W) && (w != cur);
  endfunction

  assign loc_ok = width_ok(loc_width_i, rx_w_q);
  assign rmt_ok = rx_req_i && width_ok(rx_req_width_i, rx_w_q);

  always_comb begin
    st_d     = st_q;
    tx_w_d   = tx_w_q;
    rx_w_d   = rx_w_q;
    tgt_d    = tgt_q;
    down_d   = down_q;
    req_w_d  = req_w_q;
    tx_req_d = 1'b0;
    tx_ack_d = 1'b0;
    rej_d    = 1'b0;
    l1a_d    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (l1_enter_i) begin
          l1a_d = 1'b1;
          rej_d = loc_req_i;
        end else if (rmt_ok && !(LOCAL_WINS && loc_req_i && loc_ok)) begin
          rej_d    = loc_req_i;
          tx_ack_d = 1'b1;
          tgt_d    = rx_req_width_i;
          down_d   = (rx_req_width_i < rx_w_q);
          if (rx_req_width_i < rx_w_q) begin
            tx_w_d = rx_req_width_i;
            st_d   = ST_WAIT_EIOS;
          end else begin
            st_d = ST_UPSIZE;
          end
        end else if (loc_req_i) begin
          if (loc_ok) begin
            tx_req_d = 1'b1;
            req_w_d  = loc_width_i;
            tgt_d    = loc_width_i;
            down_d   = (loc_width_i < rx_w_q);
            st_d     = ST_REQ_SENT;
          end else begin
            rej_d = 1'b1;
          end
        end
      end
      ST_REQ_SENT: begin
        rej_d = loc_req_i;
        if (l1_enter_i) begin
          l1a_d = 1'b1;
          st_d  = ST_IDLE;
        end else if (recovery_enter_i) begin
          tx_w_d = FULL_W;
          st_d   = ST_RETRAIN;
        end else if (rmt_ok && !LOCAL_WINS) begin
          tx_ack_d = 1'b1;
          tgt_d    = rx_req_width_i;
          down_d   = (rx_req_width_i < rx_w_q);
          if (rx_req_width_i < rx_w_q) begin
            tx_w_d = rx_req_width_i;
            st_d   = ST_WAIT_EIOS;
          end else begin
            st_d = ST_UPSIZE;
          end
        end else if (rx_ack_i || (down_q && eios_any)) begin
          if (down_q) begin
            tx_w_d = tgt_q;
            st_d   = ST_WAIT_EIOS;
          end else begin
            st_d = ST_UPSIZE;
          end
        end else if (chg_done) begin
          st_d = ST_IDLE;
        end
      end
      ST_WAIT_EIOS: begin
        rej_d = loc_req_i;
        if (l1_enter_i) begin
          l1a_d  = 1'b1;
          tx_w_d = rx_w_q;
          st_d   = ST_IDLE;
        end else if (recovery_enter_i) begin
          tx_w_d = FULL_W;
          st_d   = ST_RETRAIN;
        end else if (eios_all) begin
          rx_w_d = tgt_q;
          st_d   = ST_IDLE;
        end else if (eios_started && skew_done) begin
          st_d = ST_RETRAIN;
        end else if (chg_done) begin
          tx_w_d = rx_w_q;
          st_d   = ST_BLOCKED;
        end
      end
      ST_UPSIZE: begin
        rej_d = loc_req_i;
        if (l1_enter_i) begin
          l1a_d = 1'b1;
          st_d  = ST_IDLE;
        end else if (recovery_enter_i) begin
          tx_w_d = FULL_W;
          st_d   = ST_RETRAIN;
        end else if (|(lane_ts_fail_i & added)) begin
          st_d = ST_RETRAIN;
        end else if (|(lane_sds_i & added)) begin
          if (up_ready) begin
            tx_w_d = tgt_q;
            rx_w_d = tgt_q;
            st_d   = ST_IDLE;
          end else begin
            st_d = ST_RETRAIN;
          end
        end else if (chg_done) begin
          st_d = ST_BLOCKED;
        end
      end
      ST_BLOCKED: begin
        rej_d = loc_req_i;
        if (l1_enter_i) l1a_d = 1'b1;
        else if (chg_done) st_d = ST_IDLE;
      end
      ST_RETRAIN: begin
        rej_d = loc_req_i;
        if (retrain_done_i) begin
          tx_w_d = FULL_W;
          rx_w_d = FULL_W;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      tx_w_q   <= FULL_W;
      rx_w_q   <= FULL_W;
      tgt_q    <= FULL_W;
      req_w_q  <= '0;
      down_q   <= 1'b0;
      tx_req_q <= 1'b0;
      tx_ack_q <= 1'b0;
      rej_q    <= 1'b0;
      l1a_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      tx_w_q   <= tx_w_d;
      rx_w_q   <= rx_w_d;
      tgt_q    <= tgt_d;
      req_w_q  <= req_w_d;
      down_q   <= down_d;
      tx_req_q <= tx_req_d;
      tx_ack_q <= tx_ack_d;
      rej_q    <= rej_d;
      l1a_q    <= l1a_d;
    end
  end

  assign tx_req_o       = tx_req_q;
  assign tx_req_width_o = req_w_q;
  assign tx_ack_o       = tx_ack_q;
  assign req_reject_o   = rej_q;
  assign l1_ack_o       = l1a_q;
  assign retrain_o      = (st_q == ST_RETRAIN);
  assign rx_mask_o      = rx_m;

  a_r2_req_width_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> (tx_req_width_o != '0 && tx_req_width_o <= FULL_W));

  a_r4_single_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_req_o && tx_ack_o));

  a_r5_rx_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT_EIOS && !eios_all) |=> $stable(rx_mask_o));

  a_r10_blocked_rejects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BLOCKED && loc_req_i) |=> (req_reject_o && !tx_req_o));

  a_r11_l1_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1_enter_i && st_q != ST_RETRAIN) |=> (l1_ack_o && !tx_req_o && !tx_ack_o));

  a_r12_tx_full_on_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recovery_enter_i && !l1_enter_i &&
     (st_q == ST_REQ_SENT || st_q == ST_WAIT_EIOS || st_q == ST_UPSIZE))
    |=> (retrain_o && tx_mask_o == {LANES{1'b1}}));
endmodule

// File: tb/test_link_width_ctrl.sv
`timescale 1ns/1ps
module test_link_width_ctrl;
  localparam int LANES = 8;
  localparam int WW    = $clog2(LANES + 1);
  localparam int TMO   = 32;
  localparam int SKEW  = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic             loc_req_i = 0, rx_req_i = 0, rx_ack_i = 0;
  logic [WW-1:0]    loc_width_i = '0, rx_req_width_i = '0;
  logic [LANES-1:0] lane_eios_i = '0, lane_ts_done_i = '0, lane_ts_fail_i = '0;
  logic [LANES-1:0] lane_deskew_i = '0, lane_sds_i = '0;
  logic             l1_enter_i = 0, recovery_enter_i = 0, retrain_done_i = 0;

  logic tx_req_o, tx_ack_o, req_reject_o, l1_ack_o, retrain_o;
  logic [WW-1:0] tx_req_width_o;
  logic [LANES-1:0] tx_mask_o, rx_mask_o;
  logic b_tx_req, b_tx_ack, b_rej, b_l1a, b_retrain;
  logic [WW-1:0] b_req_w;
  logic [LANES-1:0] b_tx_mask, b_rx_mask;

  link_width_ctrl #(.LANES(LANES), .TMO_CYC(TMO), .SKEW_CYC(SKEW), .LOCAL_WINS(1'b1)) i_link_width_ctrl (
    .clk_i, .rst_ni, .loc_req_i, .loc_width_i, .rx_req_i, .rx_req_width_i, .rx_ack_i,
    .lane_eios_i, .lane_ts_done_i, .lane_ts_fail_i, .lane_deskew_i, .lane_sds_i,
    .l1_enter_i, .recovery_enter_i, .retrain_done_i,
    .tx_req_o, .tx_req_width_o, .tx_ack_o, .req_reject_o, .l1_ack_o, .retrain_o,
    .tx_mask_o, .rx_mask_o);

  link_width_ctrl #(.LANES(LANES), .TMO_CYC(TMO), .SKEW_CYC(SKEW), .LOCAL_WINS(1'b0)) i_link_width_ctrl_lose (
    .clk_i, .rst_ni, .loc_req_i, .loc_width_i, .rx_req_i, .rx_req_width_i, .rx_ack_i,
    .lane_eios_i, .lane_ts_done_i, .lane_ts_fail_i, .lane_deskew_i, .lane_sds_i,
    .l1_enter_i, .recovery_enter_i, .retrain_done_i,
    .tx_req_o(b_tx_req), .tx_req_width_o(b_req_w), .tx_ack_o(b_tx_ack), .req_reject_o(b_rej),
    .l1_ack_o(b_l1a), .retrain_o(b_retrain), .tx_mask_o(b_tx_mask), .rx_mask_o(b_rx_mask));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  localparam int NV = 7;
  localparam int VEC_W [NV]   = '{0, 9, 8, 15, 4, 1, 7};
  localparam bit VEC_ACC [NV] = '{0, 0, 0, 0, 1, 1, 1};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic go();
    @(negedge clk_i);
    loc_req_i = 0; rx_req_i = 0; rx_ack_i = 0;
    lane_eios_i = '0; lane_ts_done_i = '0; lane_ts_fail_i = '0;
    lane_deskew_i = '0; lane_sds_i = '0;
    l1_enter_i = 0; recovery_enter_i = 0; retrain_done_i = 0;
  endtask

  task automatic loc(input int w);
    loc_req_i = 1; loc_width_i = WW'(w);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    go();
    // R1 reset state
    chk("R1 tx_mask", tx_mask_o, 8'hFF);
    chk("R1 rx_mask", rx_mask_o, 8'hFF);
    chk("R1 outputs", {retrain_o, tx_req_o, tx_ack_o, req_reject_o, l1_ack_o}, 0);

    // R2 table walk: accepted requests time out unanswered back to idle
    for (int k = 0; k < NV; k++) begin
      loc(VEC_W[k]);
      go();
      chk($sformatf("R2 req w=%0d", VEC_W[k]), tx_req_o, VEC_ACC[k]);
      chk($sformatf("R2 rej w=%0d", VEC_W[k]), req_reject_o, !VEC_ACC[k]);
      if (VEC_ACC[k]) chk("R2 req width", tx_req_width_o, VEC_W[k]);
      repeat (TMO + 8) go();
    end

    // R4 crossing requests, both tie-break settings
    loc(4); rx_req_i = 1; rx_req_width_i = WW'(6);
    go();
    chk("R4 winner sends req", tx_req_o, 1);
    chk("R4 winner no ack", tx_ack_o, 0);
    chk("R4 loser acks", b_tx_ack, 1);
    chk("R4 loser drops req", {b_tx_req, b_rej}, 2'b01);
    chk("R4 loser adopts width", b_tx_mask, 8'h3F);
    recovery_enter_i = 1;
    go();
    chk("R12 retrain both", {retrain_o, b_retrain}, 2'b11);
    retrain_done_i = 1;
    go();
    chk("R12 retrain cleared", {retrain_o, b_retrain, tx_mask_o, b_tx_mask}, {2'b00, 8'hFF, 8'hFF});

    // R5 R13 downsize 8 -> 4
    loc(4); go();
    chk("R2 down req", tx_req_width_o, 4);
    rx_ack_i = 1; go();
    chk("R5 tx narrows on ack", tx_mask_o, 8'h0F);
    chk("R5 rx still wide", rx_mask_o, 8'hFF);
    lane_eios_i = 8'h30; go();
    chk("R5 rx waits all lanes", rx_mask_o, 8'hFF);
    lane_eios_i = 8'hC0; go();
    chk("R13 rx mask 4", rx_mask_o, 8'h0F);

    // R6 lost acknowledge, 4 -> 2
    loc(2); go();
    chk("R6 req sent", tx_req_o, 1);
    lane_eios_i = 8'h0C; go(); go();
    chk("R6 implicit ack done", {tx_mask_o, rx_mask_o}, {8'h03, 8'h03});

    // R8 upsize 2 -> 6
    loc(6); go(); rx_ack_i = 1; go();
    chk("R8 tx waits", tx_mask_o, 8'h03);
    lane_ts_done_i = 8'h3C; lane_deskew_i = 8'h3C; go();
    lane_sds_i = 8'h04; go();
    chk("R8 widened", {tx_mask_o, rx_mask_o}, {8'h3F, 8'h3F});

    // R9 start-of-data before deskew
    loc(8); go(); rx_ack_i = 1; go();
    lane_ts_done_i = 8'hC0; lane_sds_i = 8'h40; go();
    chk("R9 early sds retrain", retrain_o, 1);
    retrain_done_i = 1; go();
    chk("R12 retrain done full", {retrain_o, tx_mask_o, rx_mask_o}, {1'b0, 8'hFF, 8'hFF});

    // R3 partner downsize, then R9 training failure on partner upsize
    rx_req_i = 1; rx_req_width_i = WW'(4); go();
    chk("R3 ack", tx_ack_o, 1);
    chk("R3 tx narrows", tx_mask_o, 8'h0F);
    lane_eios_i = 8'hF0; go();
    chk("R3 rx narrows", rx_mask_o, 8'h0F);
    rx_req_i = 1; rx_req_width_i = WW'(8); go();
    chk("R3 up ack", tx_ack_o, 1);
    lane_ts_fail_i = 8'h20; go();
    chk("R9 ts fail retrain", retrain_o, 1);
    retrain_done_i = 1; go();

    // R7 partial idle detection
    loc(4); go(); rx_ack_i = 1; go();
    lane_eios_i = 8'h30; go();
    repeat (SKEW + 4) go();
    chk("R7 partial retrain", retrain_o, 1);
    chk("R7 rx unchanged", rx_mask_o, 8'hFF);
    retrain_done_i = 1; go();

    // R10 abandoned change blocks requests
    loc(4); go(); rx_ack_i = 1; go();
    repeat (40) go();
    chk("R10 width restored", tx_mask_o, 8'hFF);
    loc(2); go();
    chk("R10 blocked reject", {tx_req_o, req_reject_o}, 2'b01);
    repeat (40) go();
    loc(4); go();
    chk("R10 accepted after block", tx_req_o, 1);
    repeat (TMO + 8) go();

    // R11 low-power idle priority
    loc(4); l1_enter_i = 1; go();
    chk("R11 same cycle", {l1_ack_o, req_reject_o, tx_req_o}, 3'b110);
    loc(4); go(); rx_ack_i = 1; go();
    chk("R11 change started", tx_mask_o, 8'h0F);
    l1_enter_i = 1; go();
    chk("R11 preempt ack", l1_ack_o, 1);
    chk("R11 masks restored", {tx_mask_o, rx_mask_o}, {8'hFF, 8'hFF});

    // R12 recovery mid downsize 4 -> 2
    loc(4); go(); rx_ack_i = 1; go(); lane_eios_i = 8'hF0; go();
    loc(2); go(); rx_ack_i = 1; go();
    chk("R12 pre masks", {tx_mask_o, rx_mask_o}, {8'h03, 8'h0F});
    recovery_enter_i = 1; go();
    chk("R12 tx full rx kept", {tx_mask_o, rx_mask_o}, {8'hFF, 8'h0F});
    chk("R12 retrain", retrain_o, 1);
    retrain_done_i = 1; go();
    chk("R12 restored", {retrain_o, rx_mask_o}, {1'b0, 8'hFF});
    recovery_enter_i = 1; go();
    chk("R12 idle ignored", {retrain_o, tx_mask_o, rx_mask_o}, {1'b0, 8'hFF, 8'hFF});

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule